// File: doc/BRIEF.md
# Serial Configuration Port for a Motor Controller

This block takes an asynchronous serial byte stream and turns it into a small bank of configuration registers for a closed-loop motor controller. A receiver, clocked by an external enable that pulses at eight times the baud rate, assembles each byte. Bytes are taken in pairs: the first names a register and the second is written into it.

Nine 8-bit registers hold the settings: three loop gains, a 16-bit target position split over two bytes, a starting speed, a cruise speed, a ramp rate and a control word. The control word is decoded into a direction flag, a mode flag, a two-bit debug tap selector and a drive polarity flag. Its start and stop bits become single-cycle strobes. An address byte of zero does not select a register. It restarts the pairing and emits a one-cycle resync strobe, so a host that has lost track of the pairing can recover by sending two zero bytes.

Top module: `motor_cfg_port`

## Requirements
- R1: While reset is held and after its release, every register output is zero and every strobe is low until a write arrives.
- R2: A frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit. Each bit lasts eight `os_tick` pulses, and each bit is sampled near its middle.
- R3: A low level on `rx_in` that lasts less than half a bit period does not start a frame and causes no write.
- R4: A frame whose stop bit is sampled low is dropped. The receiver then waits for the line to go high before it looks for another start bit, and the pairing state does not change.
- R5: The first accepted byte of a pair is an address and the second is data. The data goes to the register at that address: 1 to `gain_p`, 2 to `gain_d`, 3 to `gain_i`, 6 to `vel_start`, 7 to `vel_end`, 8 to `accel`, 9 to the control word.
- R6: Address 4 writes bits 15:8 and address 5 writes bits 7:0 of `end_pos`.
- R7: A zero byte received while an address is expected raises `seq_resync` for exactly one clock and leaves the port still expecting an address. A zero received as data is stored normally, so two zero bytes always leave the port expecting an address.
- R8: A data byte that follows an address from 10 to 255 changes no register. The next byte is then taken as an address.
- R9: Control word decode: bit 0 drives `dir_cw`, bit 1 drives `mode_pos` (1 = hold position), bits 5:4 drive `tap_sel`, and bit 6 drives `pwm_invert`.
- R10: Writing the control word with bit 2 set gives a single-cycle `start_pulse`, and with bit 3 set a single-cycle `stop_pulse`. Neither strobe fires for any other write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| os_tick | input | 1 | One-clock enable at eight times the baud rate |
| rx_in | input | 1 | Asynchronous serial input, idle high |
| gain_p | output | 8 | Proportional gain (address 1) |
| gain_d | output | 8 | Derivative gain (address 2) |
| gain_i | output | 8 | Integral gain (address 3) |
| end_pos | output | 16 | Target position (addresses 4 and 5) |
| vel_start | output | 8 | Starting speed (address 6) |
| vel_end | output | 8 | Cruise speed (address 7) |
| accel | output | 8 | Ramp rate (address 8) |
| dir_cw | output | 1 | Control bit 0, clockwise |
| mode_pos | output | 1 | Control bit 1, position hold mode |
| tap_sel | output | 2 | Control bits 5:4, debug tap selector |
| pwm_invert | output | 1 | Control bit 6, drive polarity inversion |
| start_pulse | output | 1 | One-clock strobe on a control write with bit 2 set |
| stop_pulse | output | 1 | One-clock strobe on a control write with bit 3 set |
| seq_resync | output | 1 | One-clock strobe when a zero address byte arrives |

## Verification
The embedded assertions are checked on every cycle. They cover these points: a received byte is flagged only on leaving a valid stop bit, and never while the receiver waits out a bad stop. A write and a resync never coincide. An out-of-range write leaves the whole bank unchanged. The start and stop strobes last one cycle and follow a control write carrying the matching bit. Other behaviour shows only over whole frames, so the bench scenarios cover it: glitch rejection, dropping of bad frames, recovery by two zero bytes, and the address-to-register mapping. A reference model decodes the same byte stream and is compared with every output on each idle clock.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_t;

  localparam int unsigned CTL_DIR_BIT   = 0;
  localparam int unsigned CTL_MODE_BIT  = 1;
  localparam int unsigned CTL_START_BIT = 2;
  localparam int unsigned CTL_STOP_BIT  = 3;
  localparam int unsigned CTL_TAP_LSB   = 4;
  localparam int unsigned CTL_INV_BIT   = 6;
endpackage

// File: rtl/mcfg_rx.sv
module mcfg_rx
  import mcfg_pkg::*;
#(
  parameter int unsigned OSR = 8,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_async,
  output logic          byte_vld,
  output logic [DW-1:0] byte_q
);
  localparam int unsigned CW   = $clog2(OSR);
  localparam int unsigned IW   = $clog2(DW);
  localparam int unsigned HALF = OSR / 2 - 1;

  logic          rx_s1, rx_s2;
  rx_state_t     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          vld_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    if (tick) begin
      unique case (st_q)
        RX_IDLE: if (!rx_s2) begin
          st_d  = RX_START;
          cnt_d = '0;
        end
        RX_START: begin
          if (cnt_q == CW'(HALF)) begin
            cnt_d = '0;
            idx_d = '0;
            st_d  = rx_s2 ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == CW'(OSR - 1)) begin
            cnt_d = '0;
            sh_d  = {rx_s2, sh_q[DW-1:1]};
            if (idx_q == IW'(DW - 1)) st_d = RX_STOP;
            else                      idx_d = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == CW'(OSR - 1)) begin
            cnt_d = '0;
            if (rx_s2) begin
              vld_d = 1'b1;
              st_d  = RX_IDLE;
            end else begin
              st_d  = RX_HOLD;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_HOLD: if (rx_s2) st_d = RX_IDLE;
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1    <= 1'b1;
      rx_s2    <= 1'b1;
      st_q     <= RX_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      sh_q     <= '0;
      byte_vld <= 1'b0;
    end else begin
      rx_s1    <= rx_async;
      rx_s2    <= rx_s1;
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      idx_q    <= idx_d;
      sh_q     <= sh_d;
      byte_vld <= vld_d;
    end
  end

  assign byte_q = sh_q;

  // R2: a byte is flagged only on the step from a good stop bit back to idle
  a_r2_valid_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> ($past(st_q) == RX_STOP) && (st_q == RX_IDLE));

  // R4: no byte is flagged while waiting out a low stop bit
  a_r4_hold_blocks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_HOLD) |=> !byte_vld);
endmodule

// File: rtl/mcfg_seq.sv
module mcfg_seq #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_in,
  output logic          wr_en,
  output logic [DW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          resync
);
  logic          data_ph_q, data_ph_d;
  logic [DW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          wr_d, rs_d;

  always_comb begin
    data_ph_d = data_ph_q;
    addr_d    = addr_q;
    data_d    = data_q;
    wr_d      = 1'b0;
    rs_d      = 1'b0;
    if (byte_vld) begin
      if (!data_ph_q) begin
        if (byte_in == '0) begin
          rs_d = 1'b1;
        end else begin
          addr_d    = byte_in;
          data_ph_d = 1'b1;
        end
      end else begin
        data_d    = byte_in;
        wr_d      = 1'b1;
        data_ph_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_ph_q <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      wr_en     <= 1'b0;
      resync    <= 1'b0;
    end else begin
      data_ph_q <= data_ph_d;
      addr_q    <= addr_d;
      data_q    <= data_d;
      wr_en     <= wr_d;
      resync    <= rs_d;
    end
  end

  assign wr_addr = addr_q;
  assign wr_data = data_q;

  // R7: a resync and a write never share a cycle
  a_r7_resync_excludes_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, resync}));

  // R7: after a resync the port still expects an address
  a_r7_resync_keeps_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> !data_ph_q);

  // R5: a write always returns the port to the address phase
  a_r5_write_ends_pair: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !data_ph_q);
endmodule

// File: rtl/mcfg_regs.sv
module mcfg_regs
  import mcfg_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [DW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  output logic [NREG-1:0][DW-1:0]  regs,
  output logic                     start_pls,
  output logic                     stop_pls
);
  localparam int unsigned CTL_IDX = NREG - 1;

  logic [NREG-1:0]          hit;
  logic [NREG-1:0][DW-1:0]  regs_d;
  logic                     start_d, stop_d;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign hit[g]    = wr_en && (wr_addr == DW'(g + 1));
    assign regs_d[g] = hit[g] ? wr_data : regs[g];
  end

  always_comb begin
    start_d = hit[CTL_IDX] && wr_data[CTL_START_BIT];
    stop_d  = hit[CTL_IDX] && wr_data[CTL_STOP_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs      <= '0;
      start_pls <= 1'b0;
      stop_pls  <= 1'b0;
    end else begin
      regs      <= regs_d;
      start_pls <= start_d;
      stop_pls  <= stop_d;
    end
  end

  // R8: a write outside 1..NREG leaves every register as it was
  a_r8_out_of_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((wr_addr == '0) || (wr_addr > DW'(NREG)))) |=> $stable(regs));

  // R10: strobes last one cycle
  a_r10_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start_pls |=> !start_pls);
  a_r10_stop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pls |=> !stop_pls);

  // R10: a start strobe follows a control write with the start bit set
  a_r10_start_from_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
    start_pls |-> $past(wr_en && (wr_addr == DW'(NREG)) && wr_data[CTL_START_BIT]));
endmodule

// File: rtl/motor_cfg_port.sv
module motor_cfg_port
  import mcfg_pkg::*;
#(
  parameter int unsigned OSR  = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rx_in,
  output logic [7:0]    gain_p,
  output logic [7:0]    gain_d,
  output logic [7:0]    gain_i,
  output logic [15:0]   end_pos,
  output logic [7:0]    vel_start,
  output logic [7:0]    vel_end,
  output logic [7:0]    accel,
  output logic          dir_cw,
  output logic          mode_pos,
  output logic [1:0]    tap_sel,
  output logic          pwm_invert,
  output logic          start_pulse,
  output logic          stop_pulse,
  output logic          seq_resync
);
  logic                    rst_m, rst_s;
  logic                    byte_vld;
  logic [DW-1:0]           byte_q;
  logic                    wr_en;
  logic [DW-1:0]           wr_addr, wr_data;
  logic [NREG-1:0][DW-1:0] regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  mcfg_rx #(.OSR(OSR), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_s), .tick(os_tick), .rx_async(rx_in),
    .byte_vld(byte_vld), .byte_q(byte_q)
  );

  mcfg_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_s), .byte_vld(byte_vld), .byte_in(byte_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .resync(seq_resync)
  );

  mcfg_regs #(.DW(DW), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs(regs),
    .start_pls(start_pulse), .stop_pls(stop_pulse)
  );

  assign gain_p     = regs[0];
  assign gain_d     = regs[1];
  assign gain_i     = regs[2];
  assign end_pos    = {regs[3], regs[4]};
  assign vel_start  = regs[5];
  assign vel_end    = regs[6];
  assign accel      = regs[7];
  assign dir_cw     = regs[NREG-1][CTL_DIR_BIT];
  assign mode_pos   = regs[NREG-1][CTL_MODE_BIT];
  assign tap_sel    = regs[NREG-1][CTL_TAP_LSB +: 2];
  assign pwm_invert = regs[NREG-1][CTL_INV_BIT];
endmodule

// File: tb/motor_cfg_port_test.sv
module motor_cfg_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b1;
  logic [1:0] tdiv = 2'd0;
  logic os_tick;
  logic [7:0] gain_p, gain_d, gain_i, vel_start, vel_end, accel;
  logic [15:0] end_pos;
  logic dir_cw, mode_pos, pwm_invert, start_pulse, stop_pulse, seq_resync;
  logic [1:0] tap_sel;

  int checks = 0;
  int fails = 0;
  bit quiet = 1'b0;
  int n_start = 0, n_stop = 0, n_rs = 0;

  // reference model state
  int exp_r [1:9];
  bit m_data_ph = 1'b0;
  int m_addr = 0;
  int e_start = 0, e_stop = 0, e_rs = 0;
  byte unsigned pending[$];

  always #4 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign os_tick = (tdiv == 2'd3);

  always @(posedge clk) begin
    if (start_pulse) n_start++;
    if (stop_pulse)  n_stop++;
    if (seq_resync)  n_rs++;
  end

  motor_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
    .gain_p(gain_p), .gain_d(gain_d), .gain_i(gain_i), .end_pos(end_pos),
    .vel_start(vel_start), .vel_end(vel_end), .accel(accel),
    .dir_cw(dir_cw), .mode_pos(mode_pos), .tap_sel(tap_sel),
    .pwm_invert(pwm_invert), .start_pulse(start_pulse),
    .stop_pulse(stop_pulse), .seq_resync(seq_resync)
  );

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic compare_all(input string ov);
    chk(ov != "" ? ov : "R5 gain_p",     int'(gain_p),    exp_r[1]);
    chk(ov != "" ? ov : "R5 gain_d",     int'(gain_d),    exp_r[2]);
    chk(ov != "" ? ov : "R5 gain_i",     int'(gain_i),    exp_r[3]);
    chk(ov != "" ? ov : "R6 end_pos",    int'(end_pos),   (exp_r[4] << 8) | exp_r[5]);
    chk(ov != "" ? ov : "R5 vel_start",  int'(vel_start), exp_r[6]);
    chk(ov != "" ? ov : "R5 vel_end",    int'(vel_end),   exp_r[7]);
    chk(ov != "" ? ov : "R5 accel",      int'(accel),     exp_r[8]);
    chk(ov != "" ? ov : "R9 control",
        int'({pwm_invert, tap_sel, mode_pos, dir_cw}),
        (((exp_r[9] >> 6) & 1) << 4) | (((exp_r[9] >> 4) & 3) << 2) | (exp_r[9] & 3));
    chk(ov != "" ? ov : "R10 starts",    n_start, e_start);
    chk(ov != "" ? ov : "R10 stops",     n_stop,  e_stop);
    chk(ov != "" ? ov : "R7 resyncs",    n_rs,    e_rs);
  endtask

  always @(negedge clk) if (quiet) compare_all("");

  function automatic void model_byte(input int b);
    if (!m_data_ph) begin
      if (b == 0) e_rs++;
      else begin
        m_addr = b;
        m_data_ph = 1'b1;
      end
    end else begin
      if (m_addr >= 1 && m_addr <= 9) exp_r[m_addr] = b;
      if (m_addr == 9) begin
        if (b[2]) e_start++;
        if (b[3]) e_stop++;
      end
      m_data_ph = 1'b0;
    end
  endfunction

  task automatic bit_time(input logic v);
    rx_in = v;
    repeat (32) @(negedge clk);
  endtask

  task automatic frame(input byte unsigned b, input logic stop_v);
    quiet = 1'b0;
    bit_time(1'b0);
    for (int i = 0; i < 8; i++) bit_time(b[i]);
    bit_time(stop_v);
    rx_in = 1'b1;
    repeat (64) @(negedge clk);
  endtask

  // R2: good frame, model consumes the byte once the line has settled
  task automatic send(input byte unsigned b);
    pending.push_back(b);
    frame(b, 1'b1);
    model_byte(int'(pending.pop_front()));
    quiet = 1'b1;
    @(negedge clk);
  endtask

  task automatic pair(input byte unsigned a, input byte unsigned d);
    send(a);
    send(d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 1; i <= 9; i++) exp_r[i] = 0;
    repeat (5) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    compare_all("R1 after reset");
    quiet = 1'b1;

    // R5, R6: fill every data register
    pair(8'd1, 8'h11);
    pair(8'd2, 8'h22);
    pair(8'd3, 8'h33);
    pair(8'd4, 8'hA5);
    pair(8'd5, 8'h5A);
    pair(8'd6, 8'h06);
    pair(8'd7, 8'hF7);
    pair(8'd8, 8'h80);
    compare_all("R2 bytes assembled");

    // R9, R10: control writes
    pair(8'd9, 8'h77);
    pair(8'd9, 8'h0A);
    pair(8'd9, 8'h4C);
    pair(8'd9, 8'h00);

    // R8: out-of-range addresses, then a normal write
    pair(8'd12, 8'h99);
    pair(8'hFF, 8'h3C);
    compare_all("R8 out of range ignored");
    pair(8'd2, 8'h21);

    // R7: lost pairing recovered by two zeros; zeros in address phase
    send(8'd3);
    send(8'd0);
    send(8'd0);
    pair(8'd7, 8'h70);
    send(8'd0);
    send(8'd0);
    pair(8'd1, 8'h01);

    // R3: short low glitch on the line
    quiet = 1'b0;
    rx_in = 1'b0;
    repeat (8) @(negedge clk);
    rx_in = 1'b1;
    repeat (400) @(negedge clk);
    compare_all("R3 glitch rejected");
    quiet = 1'b1;
    pair(8'd6, 8'h66);

    // R4: bad stop bit inside a pair is dropped
    send(8'd8);
    frame(8'h55, 1'b0);
    compare_all("R4 bad frame dropped");
    quiet = 1'b1;
    send(8'hC3);
    compare_all("R4 pairing intact");

    repeat (20) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule